// File: doc/BRIEF.md
# Dual-Lane Fractional Multiply-Accumulate Unit

This block carries two 16x16 signed multiply-accumulate lanes that work in the same clock cycle, each with a private 40-bit accumulator. Lane 0 multiplies the low halves of the two 32-bit source words, and lane 1 multiplies the high halves. One operation code drives both lanes. It can load the accumulator with the product, add the product to it, subtract the product from it, or leave the accumulator alone and work on the bare product.

Each lane then reduces its result to 16 bits and packs it into one half of a 32-bit destination word. The reduction can use the upper half, with optional rounding, or the lower half. Results outside the 16-bit signed range saturate and raise a per-lane overflow flag. Fractional mode (the default) doubles every product. Integer mode keeps the product as multiplied. All results appear one clock after the request strobe.

Top module: `dual_mac`

## Requirements
- R1: While reset is asserted, both accumulators, the destination word, the overflow flags and the output strobe are zero.
- R2: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. Without `in_valid`, the accumulators, destination word and flags hold their values.
- R3: In fractional mode (`int_mode`=0), a lane's product is the signed 16x16 product shifted left one bit. Lane 0 uses bits [15:0] of both sources, and lane 1 uses bits [31:16].
- R4: In fractional mode, 0x8000 times 0x8000 yields 0x7FFFFFFF instead of wrapping.
- R5: In integer mode (`int_mode`=1), the product is the unshifted signed 16x16 product, so 0x8000 times 0x8000 gives 0x40000000.
- R6: `op` encoding: 0 loads the accumulator with the sign-extended product, 1 adds the product, 2 subtracts it, 3 leaves the accumulator unchanged and extracts from the bare product.
- R7: Accumulation is 40-bit two's complement and wraps at the 40-bit boundary.
- R8: When the upper half is taken (fractional mode, or `rnd_en`=1), the result is bits [31:16] of the source value. When `rnd_en`=1, 0x8000 is added to the source first.
- R9: In integer mode with `rnd_en`=0, the result is bits [15:0] of the source value, with no rounding.
- R10: If the selected 16-bit field does not hold the full signed value, the result saturates to 0x7FFF (positive) or 0x8000 (negative), and bit i of `ovf` is set for lane i. Otherwise the flag is cleared.
- R11: Lane 0's result lands in `dst[15:0]` and lane 1's in `dst[31:16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; captures operands and controls |
| op | input | 2 | Operation code (see R6) |
| int_mode | input | 1 | 1 selects signed integer, 0 signed fractional |
| rnd_en | input | 1 | Add 0x8000 before upper-half extraction |
| src_a | input | 32 | First operand word, one 16-bit half per lane |
| src_b | input | 32 | Second operand word, one 16-bit half per lane |
| acc_o | output | 80 | Lane 1 accumulator in [79:40], lane 0 in [39:0] |
| dst | output | 32 | Packed 16-bit results |
| ovf | output | 2 | Per-lane saturation flags |
| out_valid | output | 1 | Result strobe |

## Verification
The bench builds the block with its defaults: 16-bit operand halves, 40-bit accumulators and two lanes. With an 8-bit guard of headroom, about 256 full-scale additions of 0x7FFFFFFF carry the accumulator across its sign bit. The bench drives a continuous run of 300 such additions to reach the wrap, and it checks that extraction from the wrapped value saturates negative. The vector table hits the 0x8000 squared corner in both modes, a rounding carry that overflows the upper field, and saturation in both directions from the low field.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MAC_LOAD    = 2'd0,
    MAC_ADD     = 2'd1,
    MAC_SUB     = 2'd2,
    MAC_MULONLY = 2'd3
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W = 16,
  localparam int PW  = 2 * OP_W
) (
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  input  logic            int_mode_i,
  output logic [PW-1:0]   prod_o
);
  localparam logic [OP_W-1:0] MIN_OP = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [PW-1:0]   MAX_P  = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] full;
  logic                 corner;

  always_comb begin
    full   = PW'($signed(a_i)) * PW'($signed(b_i));
    corner = (a_i == MIN_OP) && (b_i == MIN_OP);
    if (int_mode_i)  prod_o = full;
    else if (corner) prod_o = MAX_P;
    else             prod_o = {full[PW-2:0], 1'b0};
  end
endmodule

// File: rtl/mac_lane.sv
module mac_lane
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  localparam int PW   = 2 * OP_W,
  localparam int EXT  = ACC_W - PW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  mac_op_e          op_i,
  input  logic             int_mode_i,
  input  logic             rnd_en_i,
  input  logic [PW-1:0]    prod_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [OP_W-1:0]  res_o,
  output logic             ovf_o
);
  localparam logic [OP_W-1:0]  POS_SAT = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0]  NEG_SAT = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] RND_K   = {{(ACC_W-OP_W){1'b0}}, 1'b1, {(OP_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d, prod_x, src, rounded, sel;
  logic [OP_W-1:0]         res_q, res_d;
  logic                    ovf_q, ovf_d, take_hi, fits;

  // next-state logic
  always_comb begin
    prod_x = {{EXT{prod_i[PW-1]}}, prod_i};
    unique case (op_i)
      MAC_LOAD: acc_d = prod_x;
      MAC_ADD:  acc_d = acc_q + prod_x;
      MAC_SUB:  acc_d = acc_q - prod_x;
      default:  acc_d = acc_q;
    endcase
    src     = (op_i == MAC_MULONLY) ? prod_x : acc_d;
    rounded = src + (RND_K & {ACC_W{rnd_en_i}});
    take_hi = !int_mode_i || rnd_en_i;
    sel     = take_hi ? (rounded >>> OP_W) : src;
    fits    = (&sel[ACC_W-1:OP_W-1]) || !(|sel[ACC_W-1:OP_W-1]);
    ovf_d   = !fits;
    if (fits)              res_d = sel[OP_W-1:0];
    else if (sel[ACC_W-1]) res_d = NEG_SAT;
    else                   res_d = POS_SAT;
  end

  // state registers with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (valid_i) begin
      acc_q <= acc_d;
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign acc_o = acc_q;
  assign res_o = res_q;
  assign ovf_o = ovf_q;

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(acc_q) && $stable(res_q) && $stable(ovf_q)));

  a_r6_mulonly_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == MAC_MULONLY) |=> $stable(acc_q));

  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == MAC_LOAD) |=> (acc_q == $past(prod_x)));

  a_r7_add_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op_i == MAC_ADD) |=> (acc_q == ACC_W'($past(acc_q) + $past(prod_x))));

  a_r10_sat_value: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (res_q == POS_SAT || res_q == NEG_SAT));
endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import mac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40,
  parameter int LANES = 2,
  localparam int WW   = LANES * OP_W,
  localparam int PW   = 2 * OP_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             op,
  input  logic                   int_mode,
  input  logic                   rnd_en,
  input  logic [WW-1:0]          src_a,
  input  logic [WW-1:0]          src_b,
  output logic [LANES*ACC_W-1:0] acc_o,
  output logic [WW-1:0]          dst,
  output logic [LANES-1:0]       ovf,
  output logic                   out_valid
);
  mac_op_e op_e;
  logic    vld_q;

  assign op_e = mac_op_e'(op);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PW-1:0] prod;

    mac_mult #(.OP_W(OP_W)) u_mul (
      .a_i        (src_a[g*OP_W +: OP_W]),
      .b_i        (src_b[g*OP_W +: OP_W]),
      .int_mode_i (int_mode),
      .prod_o     (prod)
    );

    mac_lane #(.OP_W(OP_W), .ACC_W(ACC_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (in_valid),
      .op_i       (op_e),
      .int_mode_i (int_mode),
      .rnd_en_i   (rnd_en),
      .prod_i     (prod),
      .acc_o      (acc_o[g*ACC_W +: ACC_W]),
      .res_o      (dst[g*OP_W +: OP_W]),
      .ovf_o      (ovf[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_valid;
  end
  assign out_valid = vld_q;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r4_min_square: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !int_mode && op_e == MAC_LOAD &&
     src_a[OP_W-1:0] == {1'b1, {(OP_W-1){1'b0}}} &&
     src_b[OP_W-1:0] == {1'b1, {(OP_W-1){1'b0}}})
    |=> (acc_o[ACC_W-1:0] == {{(ACC_W-PW+1){1'b0}}, {(PW-1){1'b1}}}));
endmodule

// File: tb/tb_dual_mac.sv
module tb_dual_mac;
  localparam int NV = 12;
  localparam int VW = 182;
  localparam int NADD = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        int_mode = 1'b0;
  logic        rnd_en = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [79:0] acc_o;
  logic [31:0] dst;
  logic [1:0]  ovf;
  logic        out_valid;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_mac dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .int_mode(int_mode), .rnd_en(rnd_en), .src_a(src_a), .src_b(src_b),
    .acc_o(acc_o), .dst(dst), .ovf(ovf), .out_valid(out_valid)
  );

  // op, int, rnd, a, b, acc0, acc1, dst, ovf
  localparam logic [VW-1:0] VEC [0:NV-1] = '{
    {2'd0,1'b0,1'b0,32'h4000_2000,32'h4000_4000,40'h00_1000_0000,40'h00_2000_0000,32'h2000_1000,2'b00},
    {2'd1,1'b0,1'b1,32'hC000_0001,32'h4000_4000,40'h00_1000_8000,40'h00_0000_0000,32'h0000_1001,2'b00},
    {2'd2,1'b0,1'b0,32'h8000_7FFF,32'h8000_7FFF,40'hFF_9002_7FFE,40'hFF_8000_0001,32'h8000_9002,2'b00},
    {2'd1,1'b0,1'b0,32'h7FFF_7FFF,32'h7FFF_7FFF,40'h00_1000_8000,40'hFF_FFFE_0003,32'hFFFE_1000,2'b00},
    {2'd0,1'b0,1'b0,32'h8000_8000,32'h8000_8000,40'h00_7FFF_FFFF,40'h00_7FFF_FFFF,32'h7FFF_7FFF,2'b00},
    {2'd1,1'b0,1'b0,32'h8000_8000,32'h8000_8000,40'h00_FFFF_FFFE,40'h00_FFFF_FFFE,32'h7FFF_7FFF,2'b11},
    {2'd0,1'b1,1'b0,32'h0003_FFFE,32'h0005_0007,40'hFF_FFFF_FFF2,40'h00_0000_000F,32'h000F_FFF2,2'b00},
    {2'd1,1'b1,1'b0,32'hC000_0100,32'h0004_0200,40'h00_0001_FFF2,40'hFF_FFFF_000F,32'h8000_7FFF,2'b11},
    {2'd3,1'b1,1'b1,32'h0000_0002,32'h0000_7000,40'h00_0001_FFF2,40'hFF_FFFF_000F,32'h0000_0001,2'b00},
    {2'd3,1'b0,1'b0,32'h0000_8000,32'h0000_8000,40'h00_0001_FFF2,40'hFF_FFFF_000F,32'h0000_7FFF,2'b00},
    {2'd0,1'b0,1'b1,32'h0000_8000,32'h0000_8000,40'h00_7FFF_FFFF,40'h00_0000_0000,32'h0000_7FFF,2'b01},
    {2'd0,1'b1,1'b0,32'h0000_8000,32'h0000_8000,40'h00_4000_0000,40'h00_0000_0000,32'h0000_7FFF,2'b01}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [39:0] ref_acc;
    logic [VW-1:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 acc", 64'(acc_o[39:0]) | 64'(acc_o[79:40]), 64'd0);
    chk("R1 dst/ovf/valid", {29'd0, out_valid, ovf, dst}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      v        = VEC[i];
      op       = v[181:180];
      int_mode = v[179];
      rnd_en   = v[178];
      src_a    = v[177:146];
      src_b    = v[145:114];
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R6/R3/R5 acc0 vec%0d", i), 64'(acc_o[39:0]),  64'(v[113:74]));
      chk($sformatf("R6/R4 acc1 vec%0d", i),    64'(acc_o[79:40]), 64'(v[73:34]));
      chk($sformatf("R8/R9/R11 dst vec%0d", i), 64'(dst),          64'(v[33:2]));
      chk($sformatf("R10 ovf vec%0d", i),       64'(ovf),          64'(v[1:0]));
      chk($sformatf("R2 out_valid vec%0d", i),  64'(out_valid),    64'd1);
    end

    // R2: no strobe -> outputs hold, inputs changed
    op = 2'd1; src_a = 32'h1234_5678; src_b = 32'h7FFF_7FFF; rnd_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 hold valid low", 64'(out_valid), 64'd0);
    chk("R2 hold acc0", 64'(acc_o[39:0]), 64'h00_4000_0000);
    chk("R2 hold dst/ovf", {30'd0, ovf, dst}, {30'd0, 2'b01, 32'h0000_7FFF});

    // R7: 40-bit wrap after a long run of full-scale fractional adds
    op = 2'd0; int_mode = 1'b0; rnd_en = 1'b0;
    src_a = 32'h8000_8000; src_b = 32'h8000_8000;
    in_valid = 1'b1;
    ref_acc = 40'h00_7FFF_FFFF;
    @(negedge clk);
    op = 2'd1;
    for (int k = 0; k < NADD; k++) begin
      ref_acc = ref_acc + 40'h00_7FFF_FFFF;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R7 wrap acc0", 64'(acc_o[39:0]),  64'(ref_acc));
    chk("R7 wrap acc1", 64'(acc_o[79:40]), 64'(ref_acc));
    chk("R7 sign after wrap", 64'(acc_o[39]), 64'd1);
    chk("R10 negative saturation", {30'd0, ovf, dst}, {30'd0, 2'b11, 32'h8000_8000});

    // R1: reset in mid-run clears state
    rst_n = 1'b0;
    #1;
    chk("R1 async clear acc", 64'(acc_o[39:0]) | 64'(acc_o[79:40]), 64'd0);
    chk("R1 async clear dst/ovf", {30'd0, ovf, dst}, 64'd0);
    @(negedge clk);

    summary();
    $finish;
  end
endmodule